// File: doc/BRIEF.md
# Full-Duplex Serial Packet Channel Endpoint

This block is one end of a point-to-point link between two neighbouring nodes. On the node side it offers two independent parallel packet ports with valid/ready flow control: one for packets going out to the neighbour, one for packets coming in. On the link side it drives a serial outgoing lane and listens to a serial incoming lane. Each lane has a request line, a data line and an acknowledge line. Both lanes run at the same time and neither waits for the other.

Every bit crosses the link in one four-phase request/acknowledge cycle, least significant bit first. The two ends share no clock, so the timing of the neighbour is unknown. Each direction holds exactly one packet at the sending end and one at the receiving end. This lets a node hand off a packet and carry on while a slow link moves it. When the receiving end still holds a packet that its node has not taken, the receiving end stops acknowledging. That stall reaches back to the sender.

Top module: `pkt_link_port`

## Requirements
- R1: The outgoing and incoming lanes work concurrently. A transfer in one direction never stalls or alters a transfer in the other.
- R2: An outgoing packet of PKT_W bits is sent as PKT_W four-phase handshakes, starting with bit 0. Bit i is on `out_bit` while `out_req` is high for the i-th handshake.
- R3: `tx_ready` is high only while the outgoing buffer is empty. It stays low from acceptance until the acknowledge of the final bit has returned low. No `tx_valid` is taken while `tx_ready` is low.
- R4: `out_bit` does not change while `out_req` stays high.
- R5: The incoming lane places the first bit received in bit 0 of `rx_data`. `rx_valid` rises once the PKT_W-th bit has been captured.
- R6: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold their values.
- R7: While the incoming buffer is full, `in_ack` is not raised. A pending request waits until the node takes the packet, and the transfer then completes.
- R8: `in_req` and `out_ack` each pass through a synchroniser of SYNC_STAGES flops (at least two) before the state machines act on them. `in_ack` therefore never rises in the cycle after `in_req` is first sampled high.
- R9: Reset empties both buffers, lowers `out_req` and `in_ack`, raises `tx_ready` and lowers `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | PKT_W | Outgoing packet from node |
| tx_valid | input | 1 | Outgoing packet offered |
| tx_ready | output | 1 | Outgoing buffer empty, offer accepted |
| rx_data | output | PKT_W | Incoming packet to node |
| rx_valid | output | 1 | Incoming buffer full |
| rx_ready | input | 1 | Node takes the incoming packet |
| out_req | output | 1 | Outgoing lane request |
| out_bit | output | 1 | Outgoing lane data bit |
| out_ack | input | 1 | Outgoing lane acknowledge from neighbour |
| in_req | input | 1 | Incoming lane request from neighbour |
| in_bit | input | 1 | Incoming lane data bit |
| in_ack | output | 1 | Incoming lane acknowledge |

## Verification
The bench builds the endpoint with its default 64-bit packet and the minimum two-stage synchroniser. At these values the final-bit boundary of the counters is reached at full width. The synchroniser latency is also the smallest the requirements allow, so the check on how early `in_ack` may rise is at its tightest. The neighbour is modelled with varying acknowledge delays and a withheld `rx_ready`. This puts both lanes in flight together and also holds a second packet stalled behind a full receive buffer.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;
   typedef enum logic [1:0] {
      TX_EMPTY = 2'd0,
      TX_SEND  = 2'd1,
      TX_HOLD  = 2'd2
   } tx_st_t;

   typedef enum logic {
      RX_LISTEN = 1'b0,
      RX_ACKED  = 1'b1
   } rx_st_t;
endpackage

// File: rtl/pkt_link_sync.sv
module pkt_link_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) ff[0] <= 1'b0;
               else     ff[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) ff[i] <= 1'b0;
               else     ff[i] <= ff[i-1];
            end
         end
      end
   endgenerate

   assign q = ff[STAGES-1];
endmodule

// File: rtl/pkt_link_tx.sv
module pkt_link_tx
   import pkt_link_pkg::*;
#(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   output logic         in_ready,
   output logic         req_o,
   output logic         dat_o,
   input  logic         ack_i
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   tx_st_t        st;
   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= TX_EMPTY;
         sh    <= '0;
         cnt   <= '0;
         req_o <= 1'b0;
      end else begin
         case (st)
            TX_EMPTY: if (in_valid) begin
               sh    <= in_data;
               cnt   <= '0;
               req_o <= 1'b1;
               st    <= TX_SEND;
            end
            TX_SEND: if (ack_i) begin
               req_o <= 1'b0;
               st    <= TX_HOLD;
            end
            TX_HOLD: if (!ack_i) begin
               if (cnt == LAST) begin
                  st <= TX_EMPTY;
               end else begin
                  cnt   <= cnt + 1'b1;
                  sh    <= {1'b0, sh[W-1:1]};
                  req_o <= 1'b1;
                  st    <= TX_SEND;
               end
            end
            default: st <= TX_EMPTY;
         endcase
      end
   end

   assign in_ready = (st == TX_EMPTY);
   assign dat_o    = sh[0];
endmodule

// File: rtl/pkt_link_rx.sv
module pkt_link_rx
   import pkt_link_pkg::*;
#(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   input  logic         out_ready,
   input  logic         req_i,
   input  logic         dat_i,
   output logic         ack_o
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   rx_st_t        st;
   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          full;

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= RX_LISTEN;
         sh    <= '0;
         cnt   <= '0;
         full  <= 1'b0;
         ack_o <= 1'b0;
      end else begin
         if (full && out_ready) full <= 1'b0;
         case (st)
            RX_LISTEN: if (req_i && !full) begin
               sh    <= {dat_i, sh[W-1:1]};
               ack_o <= 1'b1;
               st    <= RX_ACKED;
               if (cnt == LAST) begin
                  cnt  <= '0;
                  full <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_ACKED: if (!req_i) begin
               ack_o <= 1'b0;
               st    <= RX_LISTEN;
            end
            default: st <= RX_LISTEN;
         endcase
      end
   end

   assign out_data  = sh;
   assign out_valid = full;
endmodule

// File: rtl/pkt_link_port.sv
module pkt_link_port #(
   parameter int PKT_W       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PKT_W-1:0] tx_data,
   input  logic             tx_valid,
   output logic             tx_ready,
   output logic [PKT_W-1:0] rx_data,
   output logic             rx_valid,
   input  logic             rx_ready,
   output logic             out_req,
   output logic             out_bit,
   input  logic             out_ack,
   input  logic             in_req,
   input  logic             in_bit,
   output logic             in_ack
);
   generate
      if (PKT_W < 2) begin : g_bad_width
         $error("PKT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic ack_s;
   logic req_s;

   pkt_link_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
      .clk(clk), .rst(rst), .d(out_ack), .q(ack_s)
   );

   pkt_link_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
      .clk(clk), .rst(rst), .d(in_req), .q(req_s)
   );

   pkt_link_tx #(.W(PKT_W)) u_tx (
      .clk(clk), .rst(rst),
      .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
      .req_o(out_req), .dat_o(out_bit), .ack_i(ack_s)
   );

   pkt_link_rx #(.W(PKT_W)) u_rx (
      .clk(clk), .rst(rst),
      .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready),
      .req_i(req_s), .dat_i(in_bit), .ack_o(in_ack)
   );
endmodule

// File: rtl/pkt_link_chk.sv
module pkt_link_chk #(
   parameter int PKT_W = 64
) (
   input logic             clk,
   input logic             rst,
   input logic [PKT_W-1:0] tx_data,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [PKT_W-1:0] rx_data,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic             out_req,
   input logic             out_bit,
   input logic             out_ack,
   input logic             in_req,
   input logic             in_bit,
   input logic             in_ack
);
   assert_busy_while_req_R3: assert property (@(posedge clk) disable iff (rst)
      out_req |-> !tx_ready);

   assert_bit_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (out_req && $past(out_req)) |-> $stable(out_bit));

   assert_hold_rx_R6: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

   assert_no_ack_when_full_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(in_ack) |-> !$past(rx_valid));

   assert_sync_delay_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(in_req) |=> !$rose(in_ack));

   assert_reset_idle_R9: assert property (@(posedge clk)
      rst |=> (!out_req && !in_ack && tx_ready && !rx_valid));
endmodule

bind pkt_link_port pkt_link_chk #(.PKT_W(PKT_W)) u_chk (.*);

// File: tb/sim_pkt_link_port.sv
module sim_pkt_link_port;
   localparam int W = 64;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic tx_ready;
   logic [W-1:0] rx_data;
   logic rx_valid;
   logic rx_ready = 1'b1;
   logic out_req, out_bit;
   logic out_ack = 1'b0;
   logic in_req = 1'b0;
   logic in_bit = 1'b0;
   logic in_ack;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   int sink_bits = 0;
   int sink_pkts = 0;
   int overlap = 0;
   logic [W-1:0] txq[$];
   logic [W-1:0] rxq[$];

   always #4 clk = ~clk;

   pkt_link_port #(.PKT_W(W), .SYNC_STAGES(2)) u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // neighbour receiving the outgoing lane
   initial begin
      int dly = 1;
      logic [W-1:0] p;
      wait (!rst);
      forever begin
         for (int i = 0; i < W; i++) begin
            do @(negedge clk); while (!out_req);
            p[i] = out_bit;
            sink_bits = i + 1;
            repeat (dly) @(negedge clk);
            out_ack = 1'b1;
            do @(negedge clk); while (out_req);
            out_ack = 1'b0;
            dly = (dly % 4) + 1;
         end
         sink_bits = 0;
         sink_pkts++;
         if (txq.size() == 0) chk(0, "R2 unexpected packet", p, '0);
         else chk(p == txq[0], "R2 outgoing packet bits", p, txq[0]);
         if (txq.size() != 0) void'(txq.pop_front());
      end
   end

   // per-clock reference comparison
   always @(negedge clk) if (!rst) begin
      if (sink_bits > 0 && sink_bits < W) begin
         checks++;
         if (tx_ready) begin fails++; $display("FAIL R3 tx_ready mid packet actual=1 expected=0"); end
      end
      if (rx_valid) begin
         if (rxq.size() == 0) chk(0, "R5 rx_valid with nothing sent", rx_data, '0);
         else chk(rx_data == rxq[0], "R5 incoming packet", rx_data, rxq[0]);
         if (rx_ready && rxq.size() != 0) void'(rxq.pop_front());
      end
      if (out_req && in_req) overlap++;
   end

   task automatic put_pkt(input logic [W-1:0] p);
      do @(negedge clk); while (!tx_ready);
      tx_data = p; tx_valid = 1'b1;
      txq.push_back(p);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic send_pkt(input logic [W-1:0] p);
      rxq.push_back(p);
      for (int i = 0; i < W; i++) begin
         in_bit = p[i];
         @(negedge clk);
         in_req = 1'b1;
         do @(negedge clk); while (!in_ack);
         in_req = 1'b0;
         do @(negedge clk); while (in_ack);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9 reset state
      chk(tx_ready && !rx_valid && !out_req && !in_ack, "R9 reset state",
          {60'd0, tx_ready, rx_valid, out_req, in_ack}, {60'd0, 4'b1000});
      rst = 1'b0;
      @(negedge clk);

      // R2 R3 outgoing patterns
      put_pkt(64'h0000_0000_0000_0001);
      @(negedge clk);
      chk(!tx_ready, "R3 busy after accept", {63'd0, tx_ready}, '0);
      put_pkt(64'hFFFF_FFFF_FFFF_FFFF);
      put_pkt(64'hA5A5_5A5A_0F0F_F0F0);
      put_pkt(64'h8000_0000_0000_0000);
      do @(negedge clk); while (sink_pkts < 4);
      repeat (6) @(negedge clk);
      chk(tx_ready, "R3 empty after final ack", {63'd0, tx_ready}, 64'd1);

      // R5 incoming patterns
      send_pkt(64'h0123_4567_89AB_CDEF);
      send_pkt(64'h0000_0000_0000_0000);
      repeat (6) @(negedge clk);
      chk(rxq.size() == 0, "R5 incoming all delivered", 64'(rxq.size()), '0);

      // R6 R7 backpressure
      rx_ready = 1'b0;
      send_pkt(64'hDEAD_BEEF_CAFE_F00D);
      repeat (4) @(negedge clk);
      chk(rx_valid, "R5 rx_valid after last bit", {63'd0, rx_valid}, 64'd1);
      fork
         send_pkt(64'h1357_9BDF_2468_ACE0);
         begin
            repeat (300) @(negedge clk);
            chk(in_req && !in_ack, "R7 no ack while full", {62'd0, in_req, in_ack}, 64'd2);
            chk(rx_data == 64'hDEAD_BEEF_CAFE_F00D, "R6 held data", rx_data, 64'hDEAD_BEEF_CAFE_F00D);
            rx_ready = 1'b1;
         end
      join
      repeat (6) @(negedge clk);
      chk(rxq.size() == 0, "R7 stalled packet delivered", 64'(rxq.size()), '0);

      // R1 full duplex
      fork
         begin
            put_pkt(64'h1111_2222_3333_4444);
            put_pkt(64'h5555_6666_7777_8888);
         end
         begin
            send_pkt(64'h9999_AAAA_BBBB_CCCC);
            send_pkt(64'hDDDD_EEEE_FFFF_0000);
         end
      join
      do @(negedge clk); while (sink_pkts < 6);
      repeat (6) @(negedge clk);
      chk(overlap > 0, "R1 lanes active together", 64'(overlap), 64'd1);
      chk(txq.size() == 0 && rxq.size() == 0, "R1 both directions complete",
          64'(txq.size() + rxq.size()), '0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule